// File: doc/BRIEF.md
# Hardware Prefetch Request Queue

This block holds a short list of cache-line addresses that are waiting to be prefetched. It sits next to a cache controller. The controller reports each demand miss to it. An external address generator offers candidate prefetch addresses one at a time, and each candidate carries a delay. The block ages the queue against demand misses: it drops an entry whose line has just missed, and it can optionally discard the youngest entries whose ready time is not earlier than the new miss time.

Candidates are filtered before they are stored. Three combinational lookup inputs report whether the candidate is already in the cache or already in the miss-holding structure, and the block itself checks for a duplicate in the queue. A surviving candidate is appended in order, and the oldest entry is pushed out when the queue is full. The memory side takes entries from the head through a request/grant pair. In one mode, the cache is checked again at issue time, and an entry that has since arrived in the cache is discarded instead of issued. Eight saturating event counters report what happened to the candidates.

The option inputs are quasi-static: they may change only while reset is held.

Top module: `pf_request_queue`

## Requirements
- R1: Every address comparison and every address the block outputs uses the cache line: the byte address with its low log2(LINE_BYTES) bits cleared. `head_line` and `pf_addr` are always line aligned, and `head_line` reads 0 when the queue is empty.
- R2: A miss with `miss_uncacheable`=1 has no effect on the queue, the counters or the base time. With `cfg_data_only`=1, a miss with `miss_ifetch`=1 has no effect either.
- R3: A taken miss removes the one queued entry whose line equals the miss line, if there is one, and adds 1 to `cnt_removed`.
- R4: With `cfg_serial_squash`=1, a taken miss with time T also discards entries from the tail toward the head, for as long as each remaining entry's ready time is greater than or equal to T (unsigned compare). Each discarded entry adds 1 to `cnt_squashed`. With `cfg_serial_squash`=0, nothing is squashed.
- R5: A stored candidate's ready time is the time of the last taken miss plus `cand_delay`, modulo 2^TIME_W. Entries leave the queue in the order they were appended, and `occupancy` gives the entry count.
- R6: A candidate is dropped when `cfg_check_push`=1 and `cand_in_cache`=1; this counts `cnt_cache_hit`. Otherwise it is dropped when `cand_in_mshr`=1, which counts `cnt_mshr_hit`. Otherwise it is dropped when its line is already queued, which counts `cnt_buf_hit`. A dropped candidate is never stored.
- R7: When a candidate is stored into a queue that already holds DEPTH entries, the head entry is discarded first and `cnt_evicted` adds 1. The occupancy never exceeds DEPTH.
- R8: When the queue holds at least one entry, a grant pops the head entry. With `cfg_check_push`=1, or with `head_in_cache`=0, the popped line appears on `pf_addr` with `pf_valid`=1 in the next cycle and `cnt_issued` adds 1. Otherwise the entry is discarded silently. A grant to an empty queue does nothing.
- R9: `bus_req` is 1 exactly when the queue is non-empty. `bus_req_time` holds the ready time of the most recently stored entry.
- R10: A miss takes priority: while `miss_valid`=1, `cand_ready`=0 and the grant is ignored. A candidate handshake (`cand_valid`=1 with `cand_ready`=1) takes priority over the grant in the same cycle.
- R11: Every counter saturates at 2^CNT_W−1. `cnt_identified` counts every candidate handshake. All state clears to zero on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch misses |
| cfg_serial_squash | input | 1 | Enable squash of younger entries on a miss |
| cfg_check_push | input | 1 | Filter against the cache when a candidate is inserted (1) or when an entry is issued (0) |
| miss_valid | input | 1 | Demand miss notification |
| miss_addr | input | ADDR_W | Miss byte address |
| miss_time | input | TIME_W | Miss timestamp |
| miss_uncacheable | input | 1 | Miss is to uncacheable space |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Candidate accepted this cycle |
| cand_addr | input | ADDR_W | Candidate byte address |
| cand_delay | input | DLY_W | Candidate delay added to the miss time |
| cand_in_cache | input | 1 | Lookup result: candidate line is in the cache |
| cand_in_mshr | input | 1 | Lookup result: candidate line is in the miss-holding structure |
| head_line | output | ADDR_W | Line address of the head entry, for the issue-time lookup |
| head_in_cache | input | 1 | Lookup result: head line is in the cache |
| bus_req | output | 1 | Queue wants the memory side |
| bus_req_time | output | TIME_W | Ready time of the most recently stored entry |
| pf_grant | input | 1 | Memory side takes the head entry |
| pf_valid | output | 1 | Issued prefetch valid |
| pf_addr | output | ADDR_W | Issued prefetch line address |
| occupancy | output | $clog2(DEPTH+1) | Number of queued entries |
| cnt_identified | output | CNT_W | Candidates offered and taken |
| cnt_issued | output | CNT_W | Prefetches issued |
| cnt_evicted | output | CNT_W | Head entries discarded for room |
| cnt_squashed | output | CNT_W | Entries squashed by misses |
| cnt_removed | output | CNT_W | Entries removed by a same-line miss |
| cnt_cache_hit | output | CNT_W | Candidates dropped on a cache hit |
| cnt_mshr_hit | output | CNT_W | Candidates dropped on a miss-structure hit |
| cnt_buf_hit | output | CNT_W | Candidates dropped as duplicates |

## Verification
The assertions assume that the option inputs change only while reset is held, and that `cand_delay` fits in TIME_W bits. They also assume the lookup inputs are valid in any cycle where they are used; they need not be consistent with one another from cycle to cycle. The stimulus changes options only inside a reset pulse. It drives the lookup results as free random bits, which the reference model reads in the same cycle. Addresses come from a small pool of lines with random byte offsets, so that duplicates, same-line misses, squashes and full-queue evictions all occur.

// File: rtl/pf_request_queue.sv
module pf_request_queue #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 8,
  parameter int TIME_W     = 32,
  parameter int DLY_W      = 8,
  parameter int CNT_W      = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_data_only,
  input  logic                         cfg_serial_squash,
  input  logic                         cfg_check_push,
  input  logic                         miss_valid,
  input  logic [ADDR_W-1:0]            miss_addr,
  input  logic [TIME_W-1:0]            miss_time,
  input  logic                         miss_uncacheable,
  input  logic                         miss_ifetch,
  input  logic                         cand_valid,
  output logic                         cand_ready,
  input  logic [ADDR_W-1:0]            cand_addr,
  input  logic [DLY_W-1:0]             cand_delay,
  input  logic                         cand_in_cache,
  input  logic                         cand_in_mshr,
  output logic [ADDR_W-1:0]            head_line,
  input  logic                         head_in_cache,
  output logic                         bus_req,
  output logic [TIME_W-1:0]            bus_req_time,
  input  logic                         pf_grant,
  output logic                         pf_valid,
  output logic [ADDR_W-1:0]            pf_addr,
  output logic [$clog2(DEPTH+1)-1:0]   occupancy,
  output logic [CNT_W-1:0]             cnt_identified,
  output logic [CNT_W-1:0]             cnt_issued,
  output logic [CNT_W-1:0]             cnt_evicted,
  output logic [CNT_W-1:0]             cnt_squashed,
  output logic [CNT_W-1:0]             cnt_removed,
  output logic [CNT_W-1:0]             cnt_cache_hit,
  output logic [CNT_W-1:0]             cnt_mshr_hit,
  output logic [CNT_W-1:0]             cnt_buf_hit
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = $clog2(DEPTH);

  logic [LINE_W-1:0] e_line [DEPTH];
  logic [TIME_W-1:0] e_time [DEPTH];
  logic [LINE_W-1:0] k_line [DEPTH];
  logic [TIME_W-1:0] k_time [DEPTH];
  logic [OCC_W-1:0]  count, k_count, nxt_count;
  logic [TIME_W-1:0] base_time;
  logic [DEPTH-1:0]  vld, hit_m, hit_c, sq, keep;

  wire [LINE_W-1:0] miss_line = miss_addr[ADDR_W-1:OFF_W];
  wire [LINE_W-1:0] cand_line = cand_addr[ADDR_W-1:OFF_W];

  wire miss_take  = miss_valid && !miss_uncacheable && !(cfg_data_only && miss_ifetch);
  wire cand_fire  = cand_valid && !miss_valid;
  wire grant_fire = pf_grant && !miss_valid && !cand_valid;

  wire full         = (count == OCC_W'(DEPTH));
  wire drop_cache   = cfg_check_push && cand_in_cache;
  wire drop_mshr    = !drop_cache && cand_in_mshr;
  wire drop_buf     = !drop_cache && !cand_in_mshr && (|hit_c);
  wire c_ins        = cand_fire && !drop_cache && !cand_in_mshr && !(|hit_c);
  wire [TIME_W-1:0] ins_time = base_time + TIME_W'(cand_delay);
  wire g_issue      = grant_fire && (count != '0);
  wire g_send       = g_issue && (cfg_check_push || !head_in_cache);
  wire [OCC_W-1:0] sq_n = OCC_W'($countones(sq));

  assign cand_ready = !miss_valid;
  assign occupancy  = count;
  assign head_line  = (count != '0) ? {e_line[0], {OFF_W{1'b0}}} : '0;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld[i]   = OCC_W'(i) < count;
      hit_m[i] = vld[i] && (e_line[i] == miss_line);
      hit_c[i] = vld[i] && (e_line[i] == cand_line);
    end
  end

  always_comb begin
    logic run;
    run = 1'b1;
    sq  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld[i]) begin
        run   = run && (hit_m[i] || (cfg_serial_squash && (e_time[i] >= miss_time)));
        sq[i] = run && !hit_m[i];
      end
    end
  end

  assign keep = vld & ~hit_m & ~sq;

  always_comb begin
    logic [OCC_W-1:0] kk;
    kk = '0;
    for (int i = 0; i < DEPTH; i++) begin
      k_line[i] = e_line[i];
      k_time[i] = e_time[i];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        k_line[kk[IDX_W-1:0]] = e_line[i];
        k_time[kk[IDX_W-1:0]] = e_time[i];
        kk = kk + 1'b1;
      end
    end
    k_count = kk;
  end

  always_comb begin
    nxt_count = count;
    if (miss_take)     nxt_count = k_count;
    else if (c_ins)    nxt_count = full ? count : count + 1'b1;
    else if (g_issue)  nxt_count = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (miss_take) begin
      for (int i = 0; i < DEPTH; i++) begin
        e_line[i] <= k_line[i];
        e_time[i] <= k_time[i];
      end
    end else if (c_ins) begin
      if (full) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          e_line[i] <= e_line[i+1];
          e_time[i] <= e_time[i+1];
        end
        e_line[DEPTH-1] <= cand_line;
        e_time[DEPTH-1] <= ins_time;
      end else begin
        e_line[count[IDX_W-1:0]] <= cand_line;
        e_time[count[IDX_W-1:0]] <= ins_time;
      end
    end else if (g_issue) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        e_line[i] <= e_line[i+1];
        e_time[i] <= e_time[i+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count        <= '0;
      base_time    <= '0;
      bus_req      <= 1'b0;
      bus_req_time <= '0;
      pf_valid     <= 1'b0;
      pf_addr      <= '0;
    end else begin
      count    <= nxt_count;
      pf_valid <= g_send;
      if (miss_take) base_time <= miss_time;
      if (g_send)    pf_addr   <= {e_line[0], {OFF_W{1'b0}}};
      if (c_ins) begin
        bus_req      <= 1'b1;
        bus_req_time <= ins_time;
      end else if (nxt_count == '0) begin
        bus_req <= 1'b0;
      end
    end
  end

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [OCC_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_identified <= '0;
      cnt_issued     <= '0;
      cnt_evicted    <= '0;
      cnt_squashed   <= '0;
      cnt_removed    <= '0;
      cnt_cache_hit  <= '0;
      cnt_mshr_hit   <= '0;
      cnt_buf_hit    <= '0;
    end else begin
      cnt_identified <= sat_add(cnt_identified, OCC_W'(cand_fire));
      cnt_issued     <= sat_add(cnt_issued,     OCC_W'(g_send));
      cnt_evicted    <= sat_add(cnt_evicted,    OCC_W'(c_ins && full));
      cnt_squashed   <= sat_add(cnt_squashed,   miss_take ? sq_n : '0);
      cnt_removed    <= sat_add(cnt_removed,    OCC_W'(miss_take && (|hit_m)));
      cnt_cache_hit  <= sat_add(cnt_cache_hit,  OCC_W'(cand_fire && drop_cache));
      cnt_mshr_hit   <= sat_add(cnt_mshr_hit,   OCC_W'(cand_fire && drop_mshr));
      cnt_buf_hit    <= sat_add(cnt_buf_hit,    OCC_W'(cand_fire && drop_buf));
    end
  end
endmodule

// File: rtl/pf_request_queue_chk.sv
module pf_request_queue_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       miss_valid,
  input logic                       cand_ready,
  input logic                       pf_grant,
  input logic                       pf_valid,
  input logic                       bus_req,
  input logic [$clog2(DEPTH+1)-1:0] occupancy,
  input logic [CNT_W-1:0]           cnt_evicted,
  input logic [CNT_W-1:0]           cnt_squashed
);
  AST_MISS_BLOCKS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> !cand_ready); // R10
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH); // R7
  AST_REQ_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req == (occupancy != '0)); // R9
  AST_PF_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> ($past(pf_grant) && !$past(miss_valid))); // R8
  AST_PF_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (int'(occupancy) + 1 == int'($past(occupancy)))); // R8
  AST_EVICT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evicted != $past(cnt_evicted)) |-> (int'($past(occupancy)) == DEPTH)); // R7
  AST_SQUASH_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_squashed != $past(cnt_squashed)) |-> $past(miss_valid)); // R4
  AST_SQUASH_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_squashed >= $past(cnt_squashed)); // R11
  AST_MISS_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(miss_valid) |-> (occupancy <= $past(occupancy))); // R3
endmodule

bind pf_request_queue pf_request_queue_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_valid   (miss_valid),
  .cand_ready   (cand_ready),
  .pf_grant     (pf_grant),
  .pf_valid     (pf_valid),
  .bus_req      (bus_req),
  .occupancy    (occupancy),
  .cnt_evicted  (cnt_evicted),
  .cnt_squashed (cnt_squashed)
);

// File: tb/pf_request_queue_bench.sv
`timescale 1ns/1ps
module pf_request_queue_bench;
  localparam int AW = 16, LB = 16, DP = 4, TW = 10, DW = 4, CW = 8;
  localparam int OW = $clog2(DP + 1);
  localparam logic [AW-1:0] LMASK = ~(AW'(LB - 1));
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_do = 0, cfg_ss = 0, cfg_cp = 0;
  logic miss_valid = 0, miss_unc = 0, miss_if = 0;
  logic [AW-1:0] miss_addr = '0, cand_addr = '0;
  logic [TW-1:0] miss_time = '0;
  logic cand_valid = 0, cand_in_cache = 0, cand_in_mshr = 0, head_in_cache = 0, pf_grant = 0;
  logic [DW-1:0] cand_delay = '0;
  logic cand_ready, bus_req, pf_valid;
  logic [AW-1:0] head_line, pf_addr;
  logic [TW-1:0] bus_req_time;
  logic [OW-1:0] occupancy;
  logic [CW-1:0] c_id, c_is, c_ev, c_sq, c_rm, c_ch, c_mh, c_bh;

  always #2 clk = ~clk;

  pf_request_queue #(.ADDR_W(AW), .LINE_BYTES(LB), .DEPTH(DP), .TIME_W(TW), .DLY_W(DW), .CNT_W(CW))
  u_pf_request_queue (
    .clk(clk), .rst_n(rst_n), .cfg_data_only(cfg_do), .cfg_serial_squash(cfg_ss), .cfg_check_push(cfg_cp),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_time(miss_time),
    .miss_uncacheable(miss_unc), .miss_ifetch(miss_if),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr), .cand_delay(cand_delay),
    .cand_in_cache(cand_in_cache), .cand_in_mshr(cand_in_mshr),
    .head_line(head_line), .head_in_cache(head_in_cache),
    .bus_req(bus_req), .bus_req_time(bus_req_time), .pf_grant(pf_grant),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .occupancy(occupancy),
    .cnt_identified(c_id), .cnt_issued(c_is), .cnt_evicted(c_ev), .cnt_squashed(c_sq),
    .cnt_removed(c_rm), .cnt_cache_hit(c_ch), .cnt_mshr_hit(c_mh), .cnt_buf_hit(c_bh)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [AW-1:0] mq_addr[$];
  logic [TW-1:0] mq_time[$];
  logic [TW-1:0] m_base, m_brt;
  logic [AW-1:0] m_pfa;
  logic m_pfv, prev_ignored;
  int e_id, e_is, e_ev, e_sq, e_rm, e_ch, e_mh, e_bh;

  function automatic int sat(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    mq_addr.delete(); mq_time.delete();
    m_base = '0; m_brt = '0; m_pfa = '0; m_pfv = 0; prev_ignored = 0;
    e_id = 0; e_is = 0; e_ev = 0; e_sq = 0; e_rm = 0; e_ch = 0; e_mh = 0; e_bh = 0;
  endtask

  task automatic model_step();
    logic [AW-1:0] line;
    logic [TW-1:0] t;
    bit dup;
    m_pfv = 0;
    prev_ignored = 0;
    if (miss_valid) begin
      if (miss_unc || (cfg_do && miss_if)) begin
        prev_ignored = 1;
      end else begin
        line = miss_addr & LMASK;
        for (int i = 0; i < mq_addr.size(); i++)
          if (mq_addr[i] == line) begin
            mq_addr.delete(i); mq_time.delete(i); e_rm = sat(e_rm); break;
          end
        if (cfg_ss)
          while (mq_time.size() > 0 && mq_time[mq_time.size()-1] >= miss_time) begin
            void'(mq_addr.pop_back()); void'(mq_time.pop_back()); e_sq = sat(e_sq);
          end
        m_base = miss_time;
      end
    end else if (cand_valid) begin
      e_id = sat(e_id);
      line = cand_addr & LMASK;
      dup = 0;
      foreach (mq_addr[i]) if (mq_addr[i] == line) dup = 1;
      if (cfg_cp && cand_in_cache) e_ch = sat(e_ch);
      else if (cand_in_mshr) e_mh = sat(e_mh);
      else if (dup) e_bh = sat(e_bh);
      else begin
        t = m_base + TW'(cand_delay);
        if (mq_addr.size() == DP) begin
          void'(mq_addr.pop_front()); void'(mq_time.pop_front()); e_ev = sat(e_ev);
        end
        mq_addr.push_back(line); mq_time.push_back(t); m_brt = t;
      end
    end else if (pf_grant && mq_addr.size() > 0) begin
      line = mq_addr.pop_front(); void'(mq_time.pop_front());
      if (cfg_cp || !head_in_cache) begin
        m_pfv = 1; m_pfa = line; e_is = sat(e_is);
      end
    end
  endtask

  task automatic compare_all(input string pfx);
    chk({pfx, prev_ignored ? "R2 occupancy after ignored miss" : "R5 occupancy"}, 32'(occupancy), 32'(mq_addr.size()));
    chk({pfx, "R1 head line"}, 32'(head_line), mq_addr.size() > 0 ? 32'(mq_addr[0]) : 32'd0);
    chk({pfx, "R9 bus_req"}, 32'(bus_req), 32'(mq_addr.size() > 0));
    chk({pfx, "R9 bus_req_time"}, 32'(bus_req_time), 32'(m_brt));
    chk({pfx, "R8 pf_valid"}, 32'(pf_valid), 32'(m_pfv));
    if (m_pfv) chk({pfx, "R8 pf_addr"}, 32'(pf_addr), 32'(m_pfa));
    chk({pfx, "R11 identified"}, 32'(c_id), 32'(e_id));
    chk({pfx, "R11 issued"}, 32'(c_is), 32'(e_is));
    chk({pfx, "R7 evicted"}, 32'(c_ev), 32'(e_ev));
    chk({pfx, "R4 squashed"}, 32'(c_sq), 32'(e_sq));
    chk({pfx, "R3 removed"}, 32'(c_rm), 32'(e_rm));
    chk({pfx, "R6 cache hit"}, 32'(c_ch), 32'(e_ch));
    chk({pfx, "R6 mshr hit"}, 32'(c_mh), 32'(e_mh));
    chk({pfx, "R6 buffer hit"}, 32'(c_bh), 32'(e_bh));
  endtask

  task automatic do_reset(input logic d, input logic s, input logic c);
    @(negedge clk);
    rst_n = 0;
    miss_valid = 0; cand_valid = 0; pf_grant = 0;
    cfg_do = d; cfg_ss = s; cfg_cp = c;
    model_reset();
    repeat (3) @(negedge clk);
    compare_all("reset R11 ");
    rst_n = 1;
  endtask

  task automatic step(input int cyc, input int p_miss, input int p_cand);
    @(negedge clk);
    compare_all("");
    miss_valid    = ($urandom_range(99) < p_miss);
    miss_addr     = AW'(($urandom_range(11) << 4) | $urandom_range(15));
    miss_time     = TW'(cyc + $urandom_range(3));
    miss_unc      = ($urandom_range(3) == 0);
    miss_if       = ($urandom_range(4) < 2);
    cand_valid    = ($urandom_range(99) < p_cand);
    cand_addr     = AW'(($urandom_range(11) << 4) | $urandom_range(15));
    cand_delay    = DW'($urandom_range(15));
    cand_in_cache = ($urandom_range(4) == 0);
    cand_in_mshr  = ($urandom_range(6) == 0);
    head_in_cache = ($urandom_range(2) == 0);
    pf_grant      = ($urandom_range(99) < 40);
    #1;
    chk("R10 cand_ready", 32'(cand_ready), 32'(!miss_valid));
    model_step();
  endtask

  initial begin
    for (int w = 0; w < 200000 && !done; w++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(cfg[0], cfg[1], cfg[2]);
      for (int n = 0; n < 1200; n++) step(n, 12, 55);
      for (int n = 0; n < 300; n++) step(1200 + n, 3, 20);
    end
    @(negedge clk);
    compare_all("final ");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule